// File: doc/BRIEF.md
# Speculative Reorder Buffer with Branch Recovery

This block keeps in-flight instructions of an out-of-order core in program order. Each accepted instruction takes the entry at the tail, and that entry number becomes its destination tag. Results come back in any order on a single result bus, tagged with the entry number, and mark their entry complete. The oldest entry retires from the head only after its result is present. A retiring ALU entry writes the register file. A retiring store writes memory, which means no separate store queue is needed. A retiring branch checks the mispredict flag that came with its result.

When a branch retires with a wrong prediction, the block raises a redirect carrying the correct target. On the following edge it discards every younger entry and clears all rename mappings. A rename table records, for each architectural register, the newest entry that will write it. Operand lookups therefore return either "use the register file" or an entry tag, together with that entry's value once it has completed.

Occupancy is tracked by a three-state machine: OCC_EMPTY, OCC_PARTIAL and OCC_FULL. Its transitions are:
- alloc-first: OCC_EMPTY to OCC_PARTIAL.
- fill-up: OCC_PARTIAL to OCC_FULL, when the count reaches the depth.
- drain: OCC_PARTIAL to OCC_EMPTY, when the count reaches zero.
- release: OCC_FULL to OCC_PARTIAL, on a retire with no allocation.
- recover: OCC_PARTIAL or OCC_FULL to OCC_EMPTY, on a mispredict flush.

Top module: `rob_core`

## Requirements
- R1: `issue_ready` is 0 while the buffer holds DEPTH (8) entries. An `issue_valid` pulse while full allocates nothing and leaves `count` unchanged.
- R2: An accepted instruction receives `issue_tag` equal to the tail entry number. Tags advance by one per accepted instruction, modulo DEPTH, in issue order.
- R3: After reset, `empty`=1, `full`=0 and `count`=0. `count` equals the number of live entries, `full` is 1 exactly when `count`=DEPTH, and `empty` is 1 exactly when `count`=0.
- R4: A `res_valid` beat writes `res_value` and `res_mispredict` into the live entry numbered `res_tag` and marks it ready. A beat aimed at a free entry has no effect.
- R5: Retirement happens only at the head, and only once the head is ready. Entries that complete out of order still retire one per cycle in issue order.
- R6: A retiring ALU entry (kind code 0) drives `rf_we`=1, with `rf_waddr` = low REG_W bits of its destination and `rf_wdata` = its value.
- R7: A retiring store (kind code 1) drives `mem_we`=1, with `mem_addr` = its destination and `mem_wdata` = its value. Memory is never written before the store retires.
- R8: A retiring branch (kind code 2) with mispredict flag 0 frees its entry without any register write, memory write or redirect.
- R9: A retiring branch with mispredict flag 1 drives `redirect_valid`=1, with `redirect_pc` = its value. On the next edge all younger entries are discarded (`count`=0, `empty`=1), and none of them ever retires.
- R10: In the cycle a redirect is raised, `issue_ready` is 0 and an `issue_valid` is ignored. After the flush, the next tag is the entry just after the branch.
- R11: A lookup of a register with an in-flight writer returns `lk_busy`=1 and `lk_tag` of the newest writer. It returns `lk_ready`=1 and `lk_value` once that writer has completed. Otherwise `lk_busy`=0.
- R12: A rename mapping is cleared when its entry retires, unless a newer writer of the same register has replaced it, and all mappings are cleared on a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered for allocation |
| issue_kind | input | 2 | 0 ALU, 1 store, 2 branch |
| issue_dest | input | DEST_W | Destination register (low bits) or store address |
| issue_ready | output | 1 | Allocation possible this cycle |
| issue_tag | output | PTR_W | Entry number given to the offered instruction |
| res_valid | input | 1 | Result bus beat |
| res_tag | input | PTR_W | Entry that produced the result |
| res_value | input | DATA_W | Result, store data or branch target |
| res_mispredict | input | 1 | Branch was mispredicted |
| lk_reg | input | REG_W | Register looked up for an operand |
| lk_busy | output | 1 | Register has an in-flight writer |
| lk_tag | output | PTR_W | Newest writer entry |
| lk_ready | output | 1 | Newest writer has completed |
| lk_value | output | DATA_W | Newest writer's value |
| rf_we | output | 1 | Register file write at retirement |
| rf_waddr | output | REG_W | Register written |
| rf_wdata | output | DATA_W | Data written |
| mem_we | output | 1 | Memory write at retirement |
| mem_addr | output | DEST_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| redirect_valid | output | 1 | Fetch restart request |
| redirect_pc | output | DATA_W | Correct-path target |
| full | output | 1 | All entries in use |
| empty | output | 1 | No entries in use |
| count | output | CNT_W | Live entry count |

## Verification
The pair of functions that can land in one cycle and matter most is a mispredict retirement together with a new issue. The bench completes a mispredicted branch at the head and, in the very cycle its redirect is visible, presents a fresh ALU instruction. It judges the outcome by three observations: `issue_ready` is low in that cycle, the buffer is empty with no rename mapping left afterwards, and the next accepted tag is the entry after the branch. Younger entries that had already completed before the flush are kept out of the expected-retirement queue, so any one of them retiring is reported as an unexpected write.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        K_ALU    = 2'd0,
        K_STORE  = 2'd1,
        K_BRANCH = 2'd2
    } rob_kind_e;

    typedef struct packed {
        logic      valid;
        rob_kind_e kind;
        logic      ready;
        logic      misp;
    } rob_flags_t;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } rob_occ_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             retire_i,
    input  logic             flush_i,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);

    rob_occ_e         state_q, state_n;
    logic [CNT_W-1:0] count_n;

    // next occupancy count
    always_comb begin
        if (flush_i) begin
            count_n = '0;
        end else begin
            count_n = count_o + CNT_W'(alloc_i) - CNT_W'(retire_i);
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (alloc_i) begin
                    state_n = (count_n == CNT_W'(DEPTH)) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (flush_i || count_n == '0) begin
                    state_n = OCC_EMPTY;
                end else if (count_n == CNT_W'(DEPTH)) begin
                    state_n = OCC_FULL;
                end
            end
            OCC_FULL: begin
                if (flush_i) begin
                    state_n = OCC_EMPTY;
                end else if (count_n != CNT_W'(DEPTH)) begin
                    state_n = OCC_PARTIAL;
                end
            end
            default: state_n = OCC_EMPTY;
        endcase
    end

    // state register and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            head_o  <= '0;
            tail_o  <= '0;
            count_o <= '0;
        end else begin
            state_q <= state_n;
            count_o <= count_n;
            if (flush_i) begin
                head_o <= head_o + 1'b1;
                tail_o <= head_o + 1'b1;
            end else begin
                if (retire_i) head_o <= head_o + 1'b1;
                if (alloc_i)  tail_o <= tail_o + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        full_o  = (state_q == OCC_FULL);
        empty_o = (state_q == OCC_EMPTY);
    end

    a_r3_full_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        full_o == (count_o == CNT_W'(DEPTH)));
    a_r3_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o == (count_o == '0));
    a_r2_tail_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !flush_i) |=> tail_o == ($past(tail_o) + 1'b1));
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (count_o == '0 && head_o == tail_o));

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [PTR_W-1:0]  alloc_idx_i,
    input  rob_kind_e         alloc_kind_i,
    input  logic [DEST_W-1:0] alloc_dest_i,
    input  logic              wr_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_value_i,
    input  logic              wr_misp_i,
    input  logic              free_i,
    input  logic              flush_i,
    input  logic [PTR_W-1:0]  head_idx_i,
    input  logic [PTR_W-1:0]  lk_idx_i,
    output rob_flags_t        head_flags_o,
    output logic [DEST_W-1:0] head_dest_o,
    output logic [DATA_W-1:0] head_value_o,
    output logic              lk_ready_o,
    output logic [DATA_W-1:0] lk_value_o
);

    rob_flags_t        flags_q [DEPTH];
    logic [DEST_W-1:0] dest_q  [DEPTH];
    logic [DATA_W-1:0] value_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic hit_alloc, hit_wr, hit_free;
        assign hit_alloc = alloc_i && (alloc_idx_i == PTR_W'(g));
        assign hit_wr    = wr_i && (wr_idx_i == PTR_W'(g)) && flags_q[g].valid;
        assign hit_free  = free_i && (head_idx_i == PTR_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
                flags_q[g] <= '0;
            end else if (hit_alloc) begin
                flags_q[g] <= '{valid: 1'b1, kind: alloc_kind_i, ready: 1'b0, misp: 1'b0};
            end else if (hit_free) begin
                flags_q[g].valid <= 1'b0;
                flags_q[g].ready <= 1'b0;
            end else if (hit_wr) begin
                flags_q[g].ready <= 1'b1;
                flags_q[g].misp  <= wr_misp_i;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_alloc) dest_q[g] <= alloc_dest_i;
            if (hit_wr)    value_q[g] <= wr_value_i;
        end
    end

    always_comb begin
        head_flags_o = flags_q[head_idx_i];
        head_dest_o  = dest_q[head_idx_i];
        head_value_o = value_q[head_idx_i];
        lk_ready_o   = flags_q[lk_idx_i].valid && flags_q[lk_idx_i].ready;
        lk_value_o   = value_q[lk_idx_i];
    end

    a_r4_write_marks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && flags_q[wr_idx_i].valid && !flush_i && !(free_i && head_idx_i == wr_idx_i))
        |=> flags_q[$past(wr_idx_i)].ready);

endmodule

// File: rtl/rob_rename_table.sv
module rob_rename_table #(
    parameter int REG_W = 5,
    parameter int PTR_W = 3,
    localparam int NREG = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [REG_W-1:0] set_reg_i,
    input  logic [PTR_W-1:0] set_tag_i,
    input  logic             clr_i,
    input  logic [REG_W-1:0] clr_reg_i,
    input  logic [PTR_W-1:0] clr_tag_i,
    input  logic             flush_i,
    input  logic [REG_W-1:0] lk_reg_i,
    output logic             lk_busy_o,
    output logic [PTR_W-1:0] lk_tag_o
);

    logic [NREG-1:0]  busy_q;
    logic [PTR_W-1:0] tag_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
                busy_q[g] <= 1'b0;
            end else if (set_i && set_reg_i == REG_W'(g)) begin
                busy_q[g] <= 1'b1;
            end else if (clr_i && clr_reg_i == REG_W'(g) && tag_q[g] == clr_tag_i) begin
                busy_q[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (set_i && set_reg_i == REG_W'(g)) tag_q[g] <= set_tag_i;
        end
    end

    assign lk_busy_o = busy_q[lk_reg_i];
    assign lk_tag_o  = tag_q[lk_reg_i];

    a_r12_flush_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (busy_q == '0));
    a_r11_issue_maps_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !flush_i) |=> busy_q[$past(set_reg_i)]);

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 16,
    parameter int REG_W  = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [1:0]        issue_kind,
    input  logic [DEST_W-1:0] issue_dest,
    output logic              issue_ready,
    output logic [PTR_W-1:0]  issue_tag,
    input  logic              res_valid,
    input  logic [PTR_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic              res_mispredict,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_busy,
    output logic [PTR_W-1:0]  lk_tag,
    output logic              lk_ready,
    output logic [DATA_W-1:0] lk_value,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_we,
    output logic [DEST_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              redirect_valid,
    output logic [DATA_W-1:0] redirect_pc,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);

    logic [PTR_W-1:0]  head, tail;
    rob_flags_t        head_flags;
    logic [DEST_W-1:0] head_dest;
    logic [DATA_W-1:0] head_value;
    logic              retire, flush, alloc;
    logic              rn_busy;
    logic [PTR_W-1:0]  rn_tag;
    logic              ent_lk_ready;
    rob_kind_e         kind_in;

    assign kind_in = rob_kind_e'(issue_kind);

    // retirement decode at the head
    always_comb begin
        retire         = head_flags.valid && head_flags.ready;
        flush          = retire && head_flags.kind == K_BRANCH && head_flags.misp;
        issue_ready    = !full && !flush;
        alloc          = issue_valid && issue_ready;
        issue_tag      = tail;
        rf_we          = retire && head_flags.kind == K_ALU;
        rf_waddr       = head_dest[REG_W-1:0];
        rf_wdata       = head_value;
        mem_we         = retire && head_flags.kind == K_STORE;
        mem_addr       = head_dest;
        mem_wdata      = head_value;
        redirect_valid = flush;
        redirect_pc    = head_value;
    end

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_i  (alloc),
        .retire_i (retire),
        .flush_i  (flush),
        .head_o   (head),
        .tail_o   (tail),
        .count_o  (count),
        .full_o   (full),
        .empty_o  (empty)
    );

    rob_entry_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (alloc),
        .alloc_idx_i  (tail),
        .alloc_kind_i (kind_in),
        .alloc_dest_i (issue_dest),
        .wr_i         (res_valid),
        .wr_idx_i     (res_tag),
        .wr_value_i   (res_value),
        .wr_misp_i    (res_mispredict),
        .free_i       (retire),
        .flush_i      (flush),
        .head_idx_i   (head),
        .lk_idx_i     (rn_tag),
        .head_flags_o (head_flags),
        .head_dest_o  (head_dest),
        .head_value_o (head_value),
        .lk_ready_o   (ent_lk_ready),
        .lk_value_o   (lk_value)
    );

    rob_rename_table #(.REG_W(REG_W), .PTR_W(PTR_W)) u_rename (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (alloc && kind_in == K_ALU),
        .set_reg_i (issue_dest[REG_W-1:0]),
        .set_tag_i (tail),
        .clr_i     (rf_we),
        .clr_reg_i (rf_waddr),
        .clr_tag_i (head),
        .flush_i   (flush),
        .lk_reg_i  (lk_reg),
        .lk_busy_o (rn_busy),
        .lk_tag_o  (rn_tag)
    );

    assign lk_busy  = rn_busy;
    assign lk_tag   = rn_tag;
    assign lk_ready = rn_busy && ent_lk_ready;

    a_r5_retire_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_we || redirect_valid) |-> !empty);
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && issue_valid) |=> count <= $past(count));
    a_r10_flush_beats_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && issue_valid) |=> (empty && !lk_busy));
    a_r8_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, mem_we, redirect_valid}));

endmodule

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
module sim_rob_core;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [1:0]  issue_kind = '0;
    logic [15:0] issue_dest = '0;
    logic        issue_ready;
    logic [2:0]  issue_tag;
    logic        res_valid = 1'b0;
    logic [2:0]  res_tag = '0;
    logic [31:0] res_value = '0;
    logic        res_mispredict = 1'b0;
    logic [4:0]  lk_reg = '0;
    logic        lk_busy, lk_ready;
    logic [2:0]  lk_tag;
    logic [31:0] lk_value;
    logic        rf_we, mem_we, redirect_valid;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata, mem_wdata, redirect_pc;
    logic [15:0] mem_addr;
    logic        full, empty;
    logic [3:0]  count;

    always #(CLK_NS/2) clk = ~clk;

    rob_core u0 (.*);

    typedef struct {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [31:0] data;
    } exp_t;

    exp_t        expq[$];
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;
    logic [2:0]  exp_tail = '0;
    logic [31:0] tag_data [8];
    logic [2:0]  tg [8];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // driver: offers one instruction; pushes the expected retirement when asked
    task automatic issue(input logic [1:0] kind, input logic [15:0] dest,
                         input logic [31:0] data, input bit will_retire,
                         output logic [2:0] tag);
        chk(issue_ready == 1'b1, "R1 ready before issue", 32'(issue_ready), 1);
        chk(issue_tag == exp_tail, "R2 tag order", 32'(issue_tag), 32'(exp_tail));
        tag = issue_tag;
        tag_data[issue_tag] = data;
        issue_valid = 1'b1;
        issue_kind  = kind;
        issue_dest  = dest;
        if (will_retire) begin
            if (kind == 2'd0) expq.push_back('{kind, {11'd0, dest[4:0]}, data});
            else if (kind == 2'd1) expq.push_back('{kind, dest, data});
            else expq.push_back('{kind, 16'd0, data});
        end
        tick();
        issue_valid = 1'b0;
        exp_tail = exp_tail + 1'b1;
    endtask

    task automatic result(input logic [2:0] tag, input bit misp);
        res_valid      = 1'b1;
        res_tag        = tag;
        res_value      = tag_data[tag];
        res_mispredict = misp;
        tick();
        res_valid      = 1'b0;
        res_mispredict = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // monitor: compares every retirement against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (rf_we || mem_we || redirect_valid)) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5/R9 unexpected retirement: rf=%0b mem=%0b redir=%0b expected=none",
                         rf_we, mem_we, redirect_valid);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.kind == 2'd0) begin
                    chk(rf_we && rf_waddr == e.addr[4:0] && rf_wdata == e.data,
                        "R6 ALU retirement", {rf_we, 7'd0, 3'd0, rf_waddr, rf_wdata[15:0]},
                        {1'b1, 7'd0, 3'd0, e.addr[4:0], e.data[15:0]});
                end else if (e.kind == 2'd1) begin
                    chk(mem_we && mem_addr == e.addr && mem_wdata == e.data,
                        "R7 store retirement", {mem_addr, mem_wdata[15:0]}, {e.addr, e.data[15:0]});
                end else begin
                    chk(redirect_valid && redirect_pc == e.data,
                        "R9 redirect target", redirect_pc, e.data);
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] t;
        logic [2:0] br;
        wait_cycles(3);
        rst_n = 1'b1;
        tick();

        // R3 reset state
        chk(empty == 1'b1 && full == 1'b0 && count == 4'd0, "R3 reset state",
            {empty, full, count}, {1'b1, 1'b0, 4'd0});
        chk(issue_ready == 1'b1 && rf_we == 1'b0 && lk_busy == 1'b0, "R3 reset outputs",
            {issue_ready, rf_we, lk_busy}, 3'b100);

        // R5 out-of-order completion, in-order retirement; R11 lookup
        issue(2'd0, 16'd1, 32'h11, 1'b1, tg[0]);
        issue(2'd0, 16'd2, 32'h22, 1'b1, tg[1]);
        issue(2'd0, 16'd3, 32'h33, 1'b1, tg[2]);
        chk(count == 4'd3, "R3 count after three issues", 32'(count), 3);
        lk_reg = 5'd2;
        #1;
        chk(lk_busy && lk_tag == tg[1] && !lk_ready, "R11 pending writer",
            {lk_busy, lk_tag, lk_ready}, {1'b1, tg[1], 1'b0});
        result(tg[2], 1'b0);
        result(tg[1], 1'b0);
        chk(lk_ready && lk_value == 32'h22, "R11 completed writer value", lk_value, 32'h22);
        chk(rf_we == 1'b0, "R5 no retire while head pending", 32'(rf_we), 0);
        result(tg[0], 1'b0);
        wait_cycles(5);
        chk(empty && count == 4'd0, "R3 drained", 32'(count), 0);
        chk(lk_busy == 1'b0, "R12 mapping cleared at retirement", 32'(lk_busy), 0);

        // R7 store retires to memory only at the head
        issue(2'd1, 16'h1234, 32'hCAFE, 1'b1, t);
        wait_cycles(2);
        chk(mem_we == 1'b0, "R7 no memory write before retirement", 32'(mem_we), 0);
        result(t, 1'b0);
        wait_cycles(3);

        // R1 fill to full; refused issue; R12 newer writer keeps mapping
        for (int i = 0; i < 8; i++) issue(2'd0, 16'(8 + (i % 7)), 32'h100 + 32'(i), 1'b1, tg[i]);
        chk(full && count == 4'd8 && !issue_ready, "R1 full blocks issue",
            {full, count, issue_ready}, {1'b1, 4'd8, 1'b0});
        issue_valid = 1'b1;
        issue_kind  = 2'd0;
        issue_dest  = 16'd30;
        tick();
        issue_valid = 1'b0;
        chk(count == 4'd8 && full, "R1 refused issue leaves count", 32'(count), 8);
        for (int i = 7; i >= 0; i--) result(tg[i], 1'b0);
        lk_reg = 5'd8;
        #1;
        chk(lk_busy && lk_tag == tg[7], "R12 newer writer survives older retirement",
            {lk_busy, lk_tag}, {1'b1, tg[7]});
        wait_cycles(10);
        chk(empty && !full, "R3 empty after full drain", {empty, full}, 2'b10);

        // R4 result aimed at a free entry has no effect
        res_valid = 1'b1;
        res_tag   = exp_tail;
        res_value = 32'hDEAD;
        tick();
        res_valid = 1'b0;
        wait_cycles(2);
        chk(empty && count == 4'd0, "R4 stray result ignored", 32'(count), 0);

        // R8 correctly predicted branch retires silently
        issue(2'd2, 16'd0, 32'h999, 1'b0, br);
        issue(2'd0, 16'd20, 32'h2020, 1'b1, t);
        result(br, 1'b0);
        result(t, 1'b0);
        wait_cycles(3);
        chk(empty, "R8 branch freed", 32'(empty), 1);

        // R9/R10 mispredict with completed younger work and same-cycle issue
        issue(2'd0, 16'd5, 32'h55, 1'b1, tg[0]);
        issue(2'd2, 16'd0, 32'h400, 1'b1, br);
        issue(2'd0, 16'd6, 32'h66, 1'b0, tg[1]);
        issue(2'd1, 16'h55, 32'h77, 1'b0, tg[2]);
        result(tg[1], 1'b0);
        result(tg[2], 1'b0);
        result(tg[0], 1'b0);
        wait_cycles(2);
        lk_reg = 5'd6;
        #1;
        chk(lk_busy == 1'b1, "R11 younger writer mapped before flush", 32'(lk_busy), 1);
        res_valid      = 1'b1;
        res_tag        = br;
        res_value      = 32'h400;
        res_mispredict = 1'b1;
        tick();
        res_valid      = 1'b0;
        res_mispredict = 1'b0;
        issue_valid = 1'b1;
        issue_kind  = 2'd0;
        issue_dest  = 16'd9;
        #1;
        chk(redirect_valid && !issue_ready, "R10 redirect blocks issue",
            {redirect_valid, issue_ready}, 2'b10);
        tick();
        issue_valid = 1'b0;
        chk(empty && count == 4'd0, "R9 younger entries flushed", 32'(count), 0);
        chk(lk_busy == 1'b0, "R12 flush clears mapping", 32'(lk_busy), 0);
        lk_reg = 5'd9;
        #1;
        chk(lk_busy == 1'b0, "R10 refused issue left no mapping", 32'(lk_busy), 0);
        exp_tail = br + 1'b1;
        issue(2'd0, 16'd7, 32'h7777, 1'b1, t);
        result(t, 1'b0);
        wait_cycles(4);
        chk(empty, "R9 correct path retires", 32'(empty), 1);
        chk(expq.size() == 0, "R5 all expected retirements seen", 32'(expq.size()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule